// File: doc/BRIEF.md
# Comma-Aligned 20-Bit Deserializer

This block turns a serial bit stream, one bit per bit-clock cycle, into 20-bit parallel words. Each word carries two 10-bit 8B/10B characters. The stream comes from the line input or, when loopback is selected, from the local transmit serial stream. A 2:1 selector ahead of the shift register picks between the two.

While the alignment enable is high, the block scans the stream for the Fibre Channel comma, in either running-disparity polarity. When it finds one, it moves the character framing so that the comma character starts the next output word. The word that carries the comma is flagged. Two complementary word-rate clocks are produced, so a downstream stage can capture on either phase.

Top module: `comma_deser`

## Requirements
- R1: Bit order. The first received bit of a word appears on `word_out[19]`. `word_out[19:10]` is the first character and `word_out[9:0]` the second. Within each half, character bit a is the most significant bit.
- R2: Word rate. `word_out` and `comma_flag` change only in a cycle where `wclk_p` rises. Without realignment, a new word appears every 20 bit-clock cycles.
- R3: `wclk_n` is always the complement of `wclk_p`.
- R4: A comma is detected when character bits a..g equal `0011111` or `1100000`. After detection, the character whose bits a..g matched occupies `word_out[19:10]` of the next word, and framing continues from there in steps of 20 bits.
- R5: `comma_flag` is high for exactly the word that begins with a detected comma. It stays high until the next word and is low for all other words.
- R6: While `align_en` is low, commas are ignored. The framing does not move and `comma_flag` does not rise.
- R7: With `loop_sel` = 1 the stream is taken from `loop_bit`. With `loop_sel` = 0 it is taken from `line_bit`. A comma on the deselected input has no effect.
- R8: While `rst` is high, at every clock edge `word_out` is cleared to 0, `comma_flag` to 0, `wclk_p` to 0 and `wclk_n` to 1.
- R9: A realignment shortens or lengthens a single word period. This includes a comma found in the second half of the current framing, which moves it to the first half.
- R10: Latency. A word is presented at the bit-clock edge that follows the edge sampling its last bit on the serial input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| line_bit | input | 1 | Serial bit from the line |
| loop_bit | input | 1 | Serial bit from the local transmitter |
| loop_sel | input | 1 | 1 selects loop_bit, 0 selects line_bit |
| align_en | input | 1 | Enables comma search and realignment |
| word_out | output | 20 | Parallel word, two characters |
| comma_flag | output | 1 | Current word starts with a comma |
| wclk_p | output | 1 | Word-rate clock, rises with each new word |
| wclk_n | output | 1 | Complement of wclk_p |

## Verification
The stream is built from characters with no run longer than two, so the only possible comma matches are the inserted comma characters. A sweep places the first comma at every one of the 20 bit offsets relative to the reset framing, which separates correct realignment from a framing that only works at one phase. Each stream then carries a second comma already in phase, which must be flagged without any period change. A third comma lands half a word off, which must lengthen a period and move it to the upper half. Further streams repeat a comma with the enable low, and place commas on the deselected serial input, which distinguishes the gating and loopback paths from the plain search.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;

  // Result of one comparison of the comma window.
  typedef enum logic [1:0] {
    CK_NONE = 2'd0,
    CK_POS  = 2'd1,
    CK_NEG  = 2'd2
  } comma_kind_e;

endpackage

// File: rtl/comma_deser_in.sv
// Input stage: registered 2:1 serial selector, with the enable registered alongside the bit.
module comma_deser_in (
  input  logic clk,
  input  logic rst,
  input  logic line_bit,
  input  logic loop_bit,
  input  logic loop_sel,
  input  logic en_in,
  output logic bit_q,
  output logic en_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      bit_q <= loop_sel ? loop_bit : line_bit;
      en_q  <= en_in;
    end
  end

endmodule

// File: rtl/comma_deser_find.sv
// Combinational comma comparator over the newest COMMA_W bits.
module comma_deser_find
  import comma_deser_pkg::*;
#(
  parameter int              COMMA_W = 7,
  parameter logic [COMMA_W-1:0] PAT  = 7'b0011111,
  parameter bit              BOTH_POL = 1'b1
) (
  input  logic [COMMA_W-1:0] window_i,
  output comma_kind_e        kind_o
);

  generate
    if (BOTH_POL) begin : g_both
      always_comb begin
        if (window_i == PAT)       kind_o = CK_POS;
        else if (window_i == ~PAT) kind_o = CK_NEG;
        else                       kind_o = CK_NONE;
      end
    end else begin : g_single
      always_comb begin
        kind_o = (window_i == PAT) ? CK_POS : CK_NONE;
      end
    end
  endgenerate

endmodule

// File: rtl/comma_deser_frame.sv
// Bit counter within a word, realignment load and word-clock generation.
module comma_deser_frame #(
  parameter int WORD_W  = 20,
  parameter int COMMA_W = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  output logic emit_o,
  output logic wclk_p,
  output logic wclk_n
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(WORD_W / 2);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(COMMA_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // A hit makes the newest bit index COMMA_W-1 of a fresh word.
  always_comb begin
    emit_o = 1'b0;
    if (hit_i) begin
      cnt_d = LOAD;
    end else if (cnt_q == LAST) begin
      cnt_d  = '0;
      emit_o = 1'b1;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wclk_p <= 1'b0;
      wclk_n <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      if (emit_o) begin
        wclk_p <= 1'b1;
        wclk_n <= 1'b0;
      end else if (cnt_d == MID) begin
        wclk_p <= 1'b0;
        wclk_n <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/comma_deser_word.sv
// Shift register, output word register and comma flag.
module comma_deser_word #(
  parameter int WORD_W  = 20,
  parameter int COMMA_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_i,
  input  logic               emit_i,
  input  logic               hit_i,
  output logic [COMMA_W-1:0] window_o,
  output logic [WORD_W-1:0]  word_o,
  output logic               flag_o
);

  logic [WORD_W-2:0] sh_q;
  logic              pend_q;

  assign window_o = {sh_q[COMMA_W-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      word_o <= '0;
      flag_o <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sh_q <= {sh_q[WORD_W-3:0], bit_i};
      if (hit_i) begin
        pend_q <= 1'b1;
      end else if (emit_i) begin
        word_o <= {sh_q, bit_i};
        flag_o <= pend_q;
        pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/comma_deser.sv
module comma_deser
  import comma_deser_pkg::*;
#(
  parameter int                 CHAR_W   = 10,
  parameter int                 CHARS    = 2,
  parameter int                 COMMA_W  = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b0011111,
  parameter bit                 BOTH_POL = 1'b1,
  localparam int                WORD_W   = CHAR_W * CHARS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_bit,
  input  logic              loop_bit,
  input  logic              loop_sel,
  input  logic              align_en,
  output logic [WORD_W-1:0] word_out,
  output logic              comma_flag,
  output logic              wclk_p,
  output logic              wclk_n
);

  logic               bit_q, en_q, emit, hit;
  logic [COMMA_W-1:0] window;
  comma_kind_e        kind;

  comma_deser_in u_in (
    .clk(clk), .rst(rst), .line_bit(line_bit), .loop_bit(loop_bit),
    .loop_sel(loop_sel), .en_in(align_en), .bit_q(bit_q), .en_q(en_q)
  );

  comma_deser_find #(.COMMA_W(COMMA_W), .PAT(COMMA_PAT), .BOTH_POL(BOTH_POL)) u_find (
    .window_i(window), .kind_o(kind)
  );

  assign hit = en_q && (kind != CK_NONE);

  comma_deser_frame #(.WORD_W(WORD_W), .COMMA_W(COMMA_W)) u_frame (
    .clk(clk), .rst(rst), .hit_i(hit), .emit_o(emit),
    .wclk_p(wclk_p), .wclk_n(wclk_n)
  );

  comma_deser_word #(.WORD_W(WORD_W), .COMMA_W(COMMA_W)) u_word (
    .clk(clk), .rst(rst), .bit_i(bit_q), .emit_i(emit), .hit_i(hit),
    .window_o(window), .word_o(word_out), .flag_o(comma_flag)
  );

endmodule

// File: rtl/comma_deser_chk.sv
module comma_deser_chk #(
  parameter int WORD_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              align_en,
  input logic [WORD_W-1:0] word_out,
  input logic              comma_flag,
  input logic              wclk_p,
  input logic              wclk_n
);

  localparam int RUN_W = $clog2(2 * WORD_W) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || align_en)        low_run <= '0;
    else if (low_run != RUN_MAX) low_run <= low_run + RUN_W'(1);
  end

  // R3
  wclk_compl_chk: assert property (@(posedge clk) disable iff (rst)
    wclk_n == !wclk_p);

  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(wclk_p) |-> ($stable(word_out) && $stable(comma_flag)));

  // R5
  flag_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(comma_flag) |-> $rose(wclk_p));

  // R6
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (low_run >= RUN_W'(WORD_W)) |-> !$rose(comma_flag));

  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (word_out == '0 && !comma_flag && !wclk_p && wclk_n));

endmodule

bind comma_deser comma_deser_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .align_en(align_en), .word_out(word_out),
  .comma_flag(comma_flag), .wclk_p(wclk_p), .wclk_n(wclk_n)
);

// File: tb/comma_deser_bench.sv
`timescale 1ns/1ps
module comma_deser_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, line_bit = 1'b0, loop_bit = 1'b0, loop_sel = 1'b0, align_en = 1'b0;
  logic [19:0] word_out;
  logic        comma_flag, wclk_p, wclk_n;

  comma_deser u_comma_deser (
    .clk(clk), .rst(rst), .line_bit(line_bit), .loop_bit(loop_bit),
    .loop_sel(loop_sel), .align_en(align_en), .word_out(word_out),
    .comma_flag(comma_flag), .wclk_p(wclk_p), .wclk_n(wclk_n)
  );

  int checks = 0, errors = 0;

  // stimulus description
  logic line_s [0:511];
  logic tx_s   [0:511];
  logic en_s   [0:511];
  logic wrap_s [0:511];
  int   slen, ncm;
  int   cm [0:7];
  logic cur_en, cur_wrap, data_on_tx;
  int   dix;

  // observed words
  int          logL [0:63];
  logic [19:0] logW [0:63];
  logic        logF [0:63];
  int          nlog;

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [9:0] dchar(int i);
    case (i % 4)
      0: return 10'b1011001010;
      1: return 10'b0100110101;
      2: return 10'b1101001011;
      default: return 10'b0110100110;
    endcase
  endfunction

  function automatic logic sel_bit(int i);
    return wrap_s[i] ? tx_s[i] : line_s[i];
  endfunction

  task automatic clear_stream();
    slen = 0; ncm = 0; dix = 0;
    cur_en = 1'b1; cur_wrap = 1'b0; data_on_tx = 1'b0;
  endtask

  task automatic put_bit(logic b);
    logic alt;
    alt = (slen % 2 == 0);
    line_s[slen] = data_on_tx ? alt : b;
    tx_s[slen]   = data_on_tx ? b : ~alt;
    en_s[slen]   = cur_en;
    wrap_s[slen] = cur_wrap;
    slen++;
  endtask

  task automatic put_char(logic [9:0] ch);
    for (int i = 9; i >= 0; i--) put_bit(ch[i]);
  endtask

  task automatic put_fill(int n);
    for (int i = 0; i < n; i++) put_bit(i % 2 == 0);
  endtask

  task automatic put_data(int n);
    for (int i = 0; i < n; i++) begin
      put_char(dchar(dix));
      dix++;
    end
  endtask

  task automatic put_comma(logic neg);
    if (cur_en && (data_on_tx == cur_wrap)) begin
      cm[ncm] = slen;
      ncm++;
    end
    put_char(neg ? 10'b1100000101 : 10'b0011111010);
  endtask

  task automatic run_phase(string tag);
    logic prev_p, compl_bad;
    int nf, gi, L;
    logic [19:0] exp_w;
    logic exp_f;
    rst = 1'b1; line_bit = 1'b0; loop_bit = 1'b0; loop_sel = 1'b0; align_en = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (word_out !== 20'd0 || comma_flag !== 1'b0 || wclk_p !== 1'b0 || wclk_n !== 1'b1) begin
      errors++;
      $display("FAIL R8 reset state actual=%h/%b/%b/%b expected=00000/0/0/1",
               word_out, comma_flag, wclk_p, wclk_n);
    end
    nlog = 0; prev_p = 1'b0; compl_bad = 1'b0;
    for (int pos = 0; pos < slen + 2; pos++) begin
      if (pos > 0) @(negedge clk);
      if (wclk_n !== ~wclk_p) compl_bad = 1'b1;
      if (wclk_p === 1'b1 && prev_p === 1'b0 && nlog < 64) begin
        logL[nlog] = pos - 2;
        logW[nlog] = word_out;
        logF[nlog] = comma_flag;
        nlog++;
      end
      prev_p = wclk_p;
      rst = 1'b0;
      if (pos < slen) begin
        line_bit = line_s[pos]; loop_bit = tx_s[pos];
        loop_sel = wrap_s[pos]; align_en = en_s[pos];
      end else begin
        line_bit = 1'b0; loop_bit = 1'b0; loop_sel = 1'b0; align_en = 1'b0;
      end
    end
    nf = 0;
    for (int j = 0; j < nlog; j++) begin
      L = logL[j];
      if (logF[j]) nf++;
      gi = -1;
      for (int k = 0; k < ncm; k++) if (cm[k] + 6 <= L) gi = cm[k];
      checks++;
      if (gi < 0) begin
        if (logF[j] !== 1'b0) begin
          errors++;
          $display("FAIL R5 unaligned word flagged actual=1 expected=0 (%s)", tag);
        end
      end else if (L < gi + 19 || ((L - gi - 19) % 20) != 0) begin
        errors++;
        $display("FAIL R2 R4 R9 word end bit actual=%0d expected=%0d+20k (%s)", L, gi + 19, tag);
      end else begin
        for (int m = 0; m < 20; m++) exp_w[19 - m] = sel_bit(L - 19 + m);
        exp_f = (L == gi + 19);
        if (logW[j] !== exp_w) begin
          errors++;
          $display("FAIL R1 R10 word actual=%h expected=%h (%s)", logW[j], exp_w, tag);
        end
        checks++;
        if (logF[j] !== exp_f) begin
          errors++;
          $display("FAIL R5 flag actual=%b expected=%b (%s)", logF[j], exp_f, tag);
        end
      end
    end
    checks++;
    if (nf != ncm) begin
      errors++;
      $display("FAIL %s flagged words actual=%0d expected=%0d", tag, nf, ncm);
    end
    checks++;
    if (compl_bad) begin
      errors++;
      $display("FAIL R3 wclk_n complement actual=equal expected=inverted (%s)", tag);
    end
  endtask

  initial begin
    // R4 R9: comma at every offset, then an in-phase comma, then a half-word shifted one
    for (int o = 0; o < 20; o++) begin
      clear_stream();
      put_fill(o); put_data(3); put_comma(1'b0);
      put_data(5); put_comma(1'b1);
      put_data(4); put_comma(1'b0);
      put_data(6);
      run_phase("R4");
    end
    // R6: comma while disabled keeps old framing, re-enabled comma realigns
    clear_stream();
    put_fill(5); put_data(2); put_comma(1'b0); put_data(4);
    cur_en = 1'b0; put_fill(3); put_data(1); put_comma(1'b1); put_data(4);
    cur_en = 1'b1; put_data(1); put_fill(3); put_comma(1'b0); put_data(5);
    run_phase("R6");
    // R7: loopback path carries the comma
    clear_stream();
    cur_wrap = 1'b1; data_on_tx = 1'b1;
    put_fill(4); put_data(2); put_comma(1'b1); put_data(6);
    run_phase("R7");
    // R7: comma only on the deselected loopback input
    clear_stream();
    cur_wrap = 1'b0; data_on_tx = 1'b1;
    put_fill(6); put_data(2); put_comma(1'b0); put_data(6);
    run_phase("R7");
    // R7: comma only on the deselected line input
    clear_stream();
    cur_wrap = 1'b1; data_on_tx = 1'b0;
    put_fill(2); put_data(2); put_comma(1'b1); put_data(6);
    run_phase("R7");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule